// File: doc/BRIEF.md
# Bidirectional Thermometer Element Encoder

This block sits between a per-channel noise shaper and a bank of unit current cells. Each channel delivers a small two's complement word. For that word the block drives one enable line per current element. Half of each channel's elements push current into the output node and half pull it out. A positive word turns on that many pushing elements. A negative word turns on that many pulling elements. A zero word turns on nothing, so quiet passages put almost no element current on the output. Because both banks are filled in thermometer order, a step of one code changes exactly one line, and the transfer is monotonic.

The shaper presents all channels together with a single strobe at the shaped sample rate. The block registers the words on the strobe and registers the decoded lines one clock later. The cell enables therefore change only on that one edge and are glitch-free in between. A one-cycle flag marks the cycle in which new enables appear.

Top module: `bidir_thermo_enc`

## Requirements
- R1: While `rst` is high, at the next clock edge `elem_ctl` becomes all zero and `elem_upd` becomes low.
- R2: A word of +k (1 to 15) on a channel enables push elements 0 to k-1 of that channel and no pull element. Push element i is bit i of the channel's 32-bit slice, and channel c's slice starts at bit 32*c.
- R3: A word of -k (1 to 16) enables pull elements 0 to k-1 of that channel and no push element. Pull element i is bit 16+i of the channel slice.
- R4: A word of zero enables no element in that channel.
- R5: In no cycle does a channel have a push element and a pull element enabled together.
- R6: Push element 15 of every channel is always off.
- R7: Without a strobe, `elem_ctl` holds its value and `elem_upd` stays low, whatever `code_in` does.
- R8: For two words that differ by one and are presented back to back, the two channel slices differ in exactly one bit.
- R9: Channels are decoded independently. Channel c's word is `code_in[5*c +: 5]`.
- R10: The enables for a word strobed before clock edge n appear after edge n+1, and `elem_upd` is high for exactly that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code_valid | input | 1 | Strobe that accepts one word per channel |
| code_in | input | 10 | Per-channel shaped words, two's complement, channel 0 in the low bits |
| elem_ctl | output | 64 | Per-channel element enables: push bank in the low half, pull bank in the high half |
| elem_upd | output | 1 | High in the cycle in which new enables appear |

## Verification
Two things can happen in the same cycle: a channel's enables can be replaced, and the other channel's enables can change polarity. The bench provokes this by running an ascending sweep on one channel at full strobe rate while the other channel descends, so one bank drains as the other fills, and both channels cross zero in the same update. A scoreboard compares each update against a model written from the requirements. For each pair of adjacent words it also checks that exactly one element toggled.

// File: rtl/bte_pkg.sv
package bte_pkg;

  // Polarity selected for one channel's element banks.
  typedef enum logic [1:0] {
    POL_IDLE = 2'd0,
    POL_SRC  = 2'd1,
    POL_SNK  = 2'd2
  } pol_e;

endpackage

// File: rtl/bte_in_stage.sv
module bte_in_stage #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic [WIDTH-1:0] code_i,
  output logic             vld_q,
  output logic [WIDTH-1:0] code_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      code_q <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) code_q <= code_i;
    end
  end

endmodule

// File: rtl/bte_decode.sv
module bte_decode
  import bte_pkg::*;
#(
  parameter int CODE_W = 5,
  localparam int BANK  = 2 ** (CODE_W - 1)
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [BANK-1:0]   src_o,
  output logic [BANK-1:0]   snk_o
);

  logic [CODE_W-1:0] mag;
  pol_e              pol;

  // The magnitude fits CODE_W bits unsigned, including the most negative word.
  always_comb begin
    if (code_i[CODE_W-1]) begin
      mag = ~code_i + CODE_W'(1);
      pol = POL_SNK;
    end else if (code_i != '0) begin
      mag = code_i;
      pol = POL_SRC;
    end else begin
      mag = '0;
      pol = POL_IDLE;
    end
  end

  for (genvar i = 0; i < BANK; i++) begin : g_elem
    localparam logic [CODE_W-1:0] IDX = CODE_W'(i);
    logic on;
    assign on = (IDX < mag);
    assign snk_o[i] = on && (pol == POL_SNK);
    if (i == BANK - 1) begin : g_top_off
      assign src_o[i] = 1'b0;
    end else begin : g_src
      assign src_o[i] = on && (pol == POL_SRC);
    end
  end

endmodule

// File: rtl/bte_out_stage.sv
module bte_out_stage #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic             upd_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o   <= '0;
      upd_o <= 1'b0;
    end else begin
      upd_o <= load_i;
      if (load_i) q_o <= d_i;
    end
  end

endmodule

// File: rtl/bidir_thermo_enc.sv
module bidir_thermo_enc #(
  parameter int CODE_W = 5,
  parameter int NUM_CH = 2,
  localparam int BANK   = 2 ** (CODE_W - 1),
  localparam int ELEM_W = 2 * BANK,
  localparam int IN_W   = NUM_CH * CODE_W,
  localparam int OUT_W  = NUM_CH * ELEM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             code_valid,
  input  logic [IN_W-1:0]  code_in,
  output logic [OUT_W-1:0] elem_ctl,
  output logic             elem_upd
);

  logic             vld_q;
  logic [IN_W-1:0]  code_q;
  logic [OUT_W-1:0] elem_d;

  bte_in_stage #(.WIDTH(IN_W)) in_i (
    .clk    (clk),
    .rst    (rst),
    .vld_i  (code_valid),
    .code_i (code_in),
    .vld_q  (vld_q),
    .code_q (code_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bte_decode #(.CODE_W(CODE_W)) dec_i (
      .code_i (code_q[c*CODE_W +: CODE_W]),
      .src_o  (elem_d[c*ELEM_W +: BANK]),
      .snk_o  (elem_d[c*ELEM_W+BANK +: BANK])
    );
  end

  bte_out_stage #(.WIDTH(OUT_W)) out_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (vld_q),
    .d_i    (elem_d),
    .q_o    (elem_ctl),
    .upd_o  (elem_upd)
  );

endmodule

// File: rtl/bidir_thermo_enc_chk.sv
module bidir_thermo_enc_chk #(
  parameter int CODE_W = 5,
  parameter int NUM_CH = 2,
  localparam int BANK   = 2 ** (CODE_W - 1),
  localparam int ELEM_W = 2 * BANK,
  localparam int IN_W   = NUM_CH * CODE_W,
  localparam int OUT_W  = NUM_CH * ELEM_W
) (
  input logic             clk,
  input logic             rst,
  input logic             code_valid,
  input logic [IN_W-1:0]  code_in,
  input logic [OUT_W-1:0] elem_ctl,
  input logic             elem_upd
);

  // R7: enables move only in an update cycle
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !elem_upd |-> $stable(elem_ctl));

  // R10: a strobe is followed two edges later by the update flag
  a_r10_upd_timing: assert property (@(posedge clk) disable iff (rst)
    code_valid |=> ##1 elem_upd);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R5: banks of one channel are mutually exclusive
    a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
      !((|elem_ctl[c*ELEM_W +: BANK]) && (|elem_ctl[c*ELEM_W+BANK +: BANK])));

    // R6: the top push element is never used
    a_r6_src_top_off: assert property (@(posedge clk) disable iff (rst)
      !elem_ctl[c*ELEM_W+BANK-1]);

    // R2, R3, R4: net enabled elements equal the signed word
    a_r2_balance: assert property (@(posedge clk) disable iff (rst)
      code_valid |=> ##1
        (($countones(elem_ctl[c*ELEM_W +: BANK]) -
          $countones(elem_ctl[c*ELEM_W+BANK +: BANK])) ==
         int'($signed($past(code_in[c*CODE_W +: CODE_W], 2)))));
  end

endmodule

bind bidir_thermo_enc bidir_thermo_enc_chk #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) chk_i (.*);

// File: tb/bidir_thermo_enc_tb.sv
module bidir_thermo_enc_tb_top;

  localparam int CW    = 5;
  localparam int NCH   = 2;
  localparam int BANK  = 16;
  localparam int EW    = 32;
  localparam int IW    = NCH * CW;
  localparam int OW    = NCH * EW;

  logic          clk = 1'b0;
  logic          rst;
  logic          code_valid;
  logic [IW-1:0] code_in;
  logic [OW-1:0] elem_ctl;
  logic          elem_upd;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [OW-1:0] exp;
    bit            adj;
    string         tag;
  } item_t;

  item_t sb_q[$];
  logic [OW-1:0] prev_out;

  always #5 clk = ~clk;

  bidir_thermo_enc #(.CODE_W(CW), .NUM_CH(NCH)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .code_valid (code_valid),
    .code_in    (code_in),
    .elem_ctl   (elem_ctl),
    .elem_upd   (elem_upd)
  );

  // Model from the requirements: push bits low, pull bits high.
  function automatic logic [EW-1:0] model(int v);
    logic [EW-1:0] r = '0;
    for (int i = 0; i < BANK; i++) begin
      if (v > 0 && i < v)  r[i] = 1'b1;
      if (v < 0 && i < -v) r[BANK+i] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [OW-1:0] act, logic [OW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(int a, int b, bit adj, string tag);
    item_t it;
    @(negedge clk);
    code_valid = 1'b1;
    code_in    = {CW'(b), CW'(a)};
    it.exp = {model(b), model(a)};
    it.adj = adj;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    code_valid = 1'b0;
  endtask

  // Monitor: pops one expected item per update.
  always @(negedge clk) begin
    if (!rst && elem_upd) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R10 unexpected update", elem_ctl, prev_out);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(elem_ctl === it.exp, it.tag, elem_ctl, it.exp);
        if (it.adj) begin
          for (int c = 0; c < NCH; c++) begin
            logic [EW-1:0] d;
            d = elem_ctl[c*EW +: EW] ^ prev_out[c*EW +: EW];
            check($countones(d) == 1, "R8 one toggle per step",
                  OW'(elem_ctl[c*EW +: EW]), OW'(prev_out[c*EW +: EW]));
          end
        end
      end
      prev_out = elem_ctl;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [OW-1:0] snap;
    rst = 1'b1;
    code_valid = 1'b0;
    code_in = '1;
    prev_out = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(elem_ctl == '0 && !elem_upd, "R1 reset state", elem_ctl, '0);
    rst = 1'b0;

    send(0, 0, 0, "R4 zero word");
    send(1, 5, 0, "R2 small positive");
    send(15, 15, 0, "R2 R6 largest positive");
    send(-1, -16, 0, "R3 negative incl most negative");
    send(7, -3, 0, "R9 mixed channels");
    send(-9, 12, 0, "R9 mixed channels swapped");
    for (int v = -16; v <= 15; v++)
      send(v, -1 - v, v != -16, "R5 R8 sweep");
    idle();
    while (sb_q.size() != 0) @(negedge clk);

    // R7: words without a strobe are ignored
    repeat (2) @(negedge clk);
    snap = elem_ctl;
    code_in = {CW'(-5), CW'(4)};
    repeat (5) begin
      @(negedge clk);
      check(elem_ctl == snap && !elem_upd, "R7 hold without strobe", elem_ctl, snap);
    end

    // R10: update exactly two edges after the strobe
    send(3, -4, 0, "R10 value");
    idle();
    check(elem_ctl == snap && !elem_upd, "R10 not yet updated", elem_ctl, snap);
    @(negedge clk);
    check(elem_upd == 1'b1, "R10 update flag", OW'(elem_upd), OW'(1));
    @(negedge clk);
    check(elem_upd == 1'b0, "R10 flag one cycle", OW'(elem_upd), OW'(0));

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R10 all updates seen", OW'(sb_q.size()), '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule